// File: doc/BRIEF.md
# Data Access Bus Request Shaper

This block takes one data access request from a processor core and turns it into one or two read/write address-channel requests for an AXI bus. Each request carries a byte address, an access size, a memory type and an access kind. From these the block chooses the bus address, beat count, beat size, burst type and lock type. The bus data width (64 or 128 bits), the cache line length and a write-combining option are parameters.

A naturally aligned access is always a single beat. A misaligned access is widened to a naturally aligned container when that is legal. When it runs over a 16-byte boundary, or when ordering rules forbid merging, it becomes a pair of requests issued in ascending address order. Line fills use wrapping bursts, and line evictions use incrementing bursts of the same shape. Both the request side and the bus side use a valid/ready handshake. The input is held off while any part of an earlier request is still waiting on the bus side.

Top module: `axi_req_gen`

## Requirements
- R1: A naturally aligned load or store gives one request with length 0, a size code equal to the access size (0 byte, 1 halfword, 2 word, 3 doubleword) and the address unchanged. The burst code is 1 (incrementing) and the lock code is 0 (normal).
- R2: A line fill (kind 4) gives one wrapping burst (burst code 2). Its address is aligned to the bus width, its size equals the bus width, and its length is line bytes divided by bus bytes, minus 1. With a 64-byte line this is 7 at 64 bits and 3 at 128 bits.
- R3: A line eviction (kind 5) has the same address, length and size as a line fill, but the burst code is 1.
- R4: A swap (kind 2) drives lock code 2 and an exclusive access (kind 3) drives lock code 1. Both are single beats.
- R5: A misaligned halfword or word load or store that runs over a 16-byte boundary becomes two requests in order. The first is at the size-aligned start address. The second is at the next 16-byte boundary. Both use the access size.
- R6: A misaligned halfword or word that runs over an 8-byte boundary but not a 16-byte one is a single request. On a 64-bit bus it is at the size-aligned address with length 1. On a 128-bit bus it is one 128-bit beat at the 16-byte-aligned address.
- R7: A misaligned halfword or word that stays inside one doubleword is one beat of the smallest aligned container. This is a word (size 2) if it stays inside a word, otherwise a doubleword (size 3).
- R8: A misaligned doubleword that is strongly ordered or device (memory type 1), or that is a load, becomes two 32-bit requests at the start address and at the start address plus 4. Doubleword accesses are at least word aligned.
- R9: A misaligned noncacheable (memory type 0) doubleword store that stays inside 16 bytes behaves as follows. On a 64-bit bus with write combining it is one request with length 1 and size 2. On a 64-bit bus without write combining it is split as in R8. On a 128-bit bus it is one 128-bit beat at the 16-byte-aligned address.
- R10: A table walk fetch (kind 6) is one incrementing word beat at the word-aligned address with length 0.
- R11: The second request of a pair is presented only after the first has been accepted. While the output is valid and not ready, every output field holds its value.
- R12: The input ready is low from the acceptance of a request until its last bus request has been accepted.
- R13: After reset the output valid is low and the input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted when high with valid |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size code, 0 byte to 3 doubleword |
| req_attr | input | 2 | Memory type: 0 noncacheable, 1 strongly ordered/device, 2 cacheable |
| req_kind | input | 3 | 0 load, 1 store, 2 swap, 3 exclusive, 4 line fill, 5 eviction, 6 table walk |
| ax_valid | output | 1 | Bus address request valid |
| ax_ready | input | 1 | Bus address request accepted |
| ax_addr | output | 32 | Bus address |
| ax_len | output | 4 | Beats minus one |
| ax_size | output | 3 | Log2 of bytes per beat |
| ax_burst | output | 2 | 1 incrementing, 2 wrapping |
| ax_lock | output | 2 | 0 normal, 1 exclusive, 2 locked |

## Verification
A request is taken on the rising edge where valid and ready are both high. Its first bus request appears right after that edge. With bus ready high, a second request of a pair appears one clock later, and the block is idle again one clock after that. The bench drives inputs and samples outputs on falling edges. It logs each bus handshake, then waits five falling edges before it compares the number and content of the logged beats with literal expected values. A stalled-bus scenario checks the held outputs and the low input ready at every falling edge of the stall and of the release.

// File: rtl/axi_req_pkg.sv
package axi_req_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [2:0] {
    K_LOAD  = 3'd0,
    K_STORE = 3'd1,
    K_SWAP  = 3'd2,
    K_EXCL  = 3'd3,
    K_FILL  = 3'd4,
    K_EVICT = 3'd5,
    K_WALK  = 3'd6
  } kind_e;

  localparam logic [1:0] MEM_NC    = 2'd0;
  localparam logic [1:0] MEM_SO    = 2'd1;

  localparam logic [1:0] BURST_INCR = 2'd1;
  localparam logic [1:0] BURST_WRAP = 2'd2;

  localparam logic [1:0] LOCK_NORMAL = 2'd0;
  localparam logic [1:0] LOCK_EXCL   = 2'd1;
  localparam logic [1:0] LOCK_LOCKED = 2'd2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [3:0]        len;
    logic [2:0]        size;
    logic [1:0]        burst;
    logic [1:0]        lock;
  } beat_t;

  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                    input int unsigned k);
    return (a >> k) << k;
  endfunction
endpackage

// File: rtl/axi_req_decode.sv
module axi_req_decode
  import axi_req_pkg::*;
#(
  parameter int BUS_BITS   = 64,
  parameter int LINE_BYTES = 64,
  parameter bit WRITE_COMB = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [1:0]        attr,
  input  kind_e             kind,
  output beat_t             first,
  output beat_t             second,
  output logic              split
);
  localparam int BUS_BYTES = BUS_BITS / 8;
  localparam int BUS_LG    = $clog2(BUS_BYTES);
  localparam int LINE_LEN  = LINE_BYTES / BUS_BYTES - 1;
  localparam bit WIDE      = (BUS_BITS > 64);

  logic [4:0] nbytes, end16, end8, end4;
  logic       cross16, cross8, cross4, misal, merge_store;
  logic [1:0] lk;

  always_comb begin
    nbytes  = 5'd1 << size;
    end16   = {1'b0, addr[3:0]} + nbytes;
    end8    = {2'b0, addr[2:0]} + nbytes;
    end4    = {3'b0, addr[1:0]} + nbytes;
    cross16 = end16 > 5'd16;
    cross8  = end8 > 5'd8;
    cross4  = end4 > 5'd4;
    misal   = (addr[2:0] & (nbytes[2:0] - 3'd1)) != 3'd0;
    merge_store = (kind == K_STORE) && (attr == MEM_NC) && !cross16 && (WIDE || WRITE_COMB);

    case (kind)
      K_SWAP:  lk = LOCK_LOCKED;
      K_EXCL:  lk = LOCK_EXCL;
      default: lk = LOCK_NORMAL;
    endcase

    first.addr  = addr;
    first.len   = 4'd0;
    first.size  = {1'b0, size};
    first.burst = BURST_INCR;
    first.lock  = lk;
    split       = 1'b0;
    second      = first;

    case (kind)
      K_FILL, K_EVICT: begin
        first.addr  = align_down(addr, BUS_LG);
        first.len   = LINE_LEN[3:0];
        first.size  = BUS_LG[2:0];
        first.burst = (kind == K_FILL) ? BURST_WRAP : BURST_INCR;
      end
      K_WALK: begin
        first.addr = align_down(addr, 2);
        first.size = 3'd2;
      end
      default: begin
        if (!misal) begin
          first.addr = align_down(addr, int'(size));
        end else if (size == 2'd3) begin
          if (merge_store) begin
            if (WIDE) begin
              first.addr = align_down(addr, BUS_LG);
              first.size = BUS_LG[2:0];
            end else begin
              first.addr = align_down(addr, 2);
              first.len  = 4'd1;
              first.size = 3'd2;
            end
          end else begin
            split       = 1'b1;
            first.addr  = align_down(addr, 2);
            first.size  = 3'd2;
          end
        end else if (cross16) begin
          split      = 1'b1;
          first.addr = align_down(addr, int'(size));
        end else if (cross8) begin
          if (WIDE) begin
            first.addr = align_down(addr, BUS_LG);
            first.size = BUS_LG[2:0];
          end else begin
            first.addr = align_down(addr, int'(size));
            first.len  = 4'd1;
          end
        end else if (cross4) begin
          first.addr = align_down(addr, 3);
          first.size = 3'd3;
        end else begin
          first.addr = align_down(addr, 2);
          first.size = 3'd2;
        end
      end
    endcase

    second = first;
    if (size == 2'd3)
      second.addr = first.addr + ADDR_W'(4);
    else
      second.addr = align_down(addr, 4) + ADDR_W'(16);
  end
endmodule

// File: rtl/axi_req_seq.sv
module axi_req_seq
  import axi_req_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  output logic  in_ready,
  input  beat_t first,
  input  beat_t second,
  input  logic  split,
  output logic  out_valid,
  input  logic  out_ready,
  output beat_t out_beat
);
  logic  pend;
  beat_t sec_q;

  assign in_ready = !out_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      pend      <= 1'b0;
      out_beat  <= '0;
      sec_q     <= '0;
    end else if (!out_valid) begin
      if (in_valid) begin
        out_valid <= 1'b1;
        out_beat  <= first;
        sec_q     <= second;
        pend      <= split;
      end
    end else if (out_ready) begin
      if (pend) begin
        out_beat <= sec_q;
        pend     <= 1'b0;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R13
  AST_PEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    pend |-> out_valid && !in_ready); // R12
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_beat)); // R11
  AST_SECOND_ABOVE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && pend |=> out_valid && (out_beat.addr > $past(out_beat.addr))); // R5
  AST_LOCKED_SINGLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_beat.lock != LOCK_NORMAL) |-> out_beat.len == 4'd0); // R4
endmodule

// File: rtl/axi_req_gen.sv
module axi_req_gen
  import axi_req_pkg::*;
#(
  parameter int BUS_BITS   = 64,
  parameter int LINE_BYTES = 64,
  parameter bit WRITE_COMB = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_attr,
  input  logic [2:0]        req_kind,
  output logic              ax_valid,
  input  logic              ax_ready,
  output logic [ADDR_W-1:0] ax_addr,
  output logic [3:0]        ax_len,
  output logic [2:0]        ax_size,
  output logic [1:0]        ax_burst,
  output logic [1:0]        ax_lock
);
  beat_t first, second, cur;
  logic  split;

  axi_req_decode #(
    .BUS_BITS(BUS_BITS), .LINE_BYTES(LINE_BYTES), .WRITE_COMB(WRITE_COMB)
  ) i_decode (
    .addr(req_addr), .size(req_size), .attr(req_attr), .kind(kind_e'(req_kind)),
    .first(first), .second(second), .split(split)
  );

  axi_req_seq i_seq (
    .clk(clk), .rst(rst), .in_valid(req_valid), .in_ready(req_ready),
    .first(first), .second(second), .split(split),
    .out_valid(ax_valid), .out_ready(ax_ready), .out_beat(cur)
  );

  assign ax_addr  = cur.addr;
  assign ax_len   = cur.len;
  assign ax_size  = cur.size;
  assign ax_burst = cur.burst;
  assign ax_lock  = cur.lock;
endmodule

// File: tb/test_axi_req_gen.sv
module test_axi_req_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rv = 1'b0;
  logic [31:0] raddr = '0;
  logic [1:0]  rsize = '0, rattr = '0;
  logic [2:0]  rkind = '0;
  logic        rrdy [NI];
  logic        ov   [NI];
  logic        ordy [NI];
  logic [31:0] oa   [NI];
  logic [3:0]  ol   [NI];
  logic [2:0]  os   [NI];
  logic [1:0]  ob   [NI];
  logic [1:0]  olk  [NI];
  logic [42:0] cap  [NI][512];
  int          cnt  [NI];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // instance 0: 64-bit, write combining; 1: 128-bit; 2: 64-bit, no write combining
  for (genvar g = 0; g < NI; g++) begin : g_dut
    localparam int BW = (g == 1) ? 128 : 64;
    localparam bit WC = (g == 2) ? 1'b0 : 1'b1;
    axi_req_gen #(.BUS_BITS(BW), .LINE_BYTES(64), .WRITE_COMB(WC)) i_axi_req_gen (
      .clk(clk), .rst(rst), .req_valid(rv), .req_ready(rrdy[g]),
      .req_addr(raddr), .req_size(rsize), .req_attr(rattr), .req_kind(rkind),
      .ax_valid(ov[g]), .ax_ready(ordy[g]), .ax_addr(oa[g]), .ax_len(ol[g]),
      .ax_size(os[g]), .ax_burst(ob[g]), .ax_lock(olk[g])
    );
    initial cnt[g] = 0;
    always @(negedge clk)
      if (!rst && ov[g] && ordy[g] && cnt[g] < 512) begin
        cap[g][cnt[g]] = {oa[g], ol[g], os[g], ob[g], olk[g]};
        cnt[g] = cnt[g] + 1;
      end
  end

  function automatic logic [42:0] bt(input logic [31:0] a, input logic [3:0] l,
                                     input logic [2:0] s, input logic [1:0] b, input logic [1:0] k);
    return {a, l, s, b, k};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input logic [31:0] a, input logic [1:0] s,
                          input logic [1:0] at, input logic [2:0] k,
                          input int n0, input logic [42:0] e00, input logic [42:0] e01,
                          input int n1, input logic [42:0] e10, input logic [42:0] e11,
                          input int n2, input logic [42:0] e20, input logic [42:0] e21);
    int base [NI];
    int n [NI];
    logic [42:0] e [NI][2];
    n[0] = n0; n[1] = n1; n[2] = n2;
    e[0][0] = e00; e[0][1] = e01; e[1][0] = e10; e[1][1] = e11; e[2][0] = e20; e[2][1] = e21;
    @(negedge clk);
    for (int g = 0; g < NI; g++) base[g] = cnt[g];
    raddr = a; rsize = s; rattr = at; rkind = k; rv = 1'b1;
    @(negedge clk);
    rv = 1'b0;
    repeat (5) @(negedge clk);
    for (int g = 0; g < NI; g++) begin
      chk($sformatf("%s inst%0d count", tag, g), 64'(cnt[g] - base[g]), 64'(n[g]));
      for (int i = 0; i < n[g] && i < 2; i++)
        chk($sformatf("%s inst%0d beat%0d", tag, g, i), 64'(cap[g][base[g] + i]), 64'(e[g][i]));
    end
  endtask

  task automatic run_same(input string tag, input logic [31:0] a, input logic [1:0] s,
                          input logic [1:0] at, input logic [2:0] k,
                          input int n, input logic [42:0] e0, input logic [42:0] e1);
    run_case(tag, a, s, at, k, n, e0, e1, n, e0, e1, n, e0, e1);
  endtask

  task automatic t_reset;
    for (int g = 0; g < NI; g++) begin
      chk($sformatf("R13 inst%0d valid", g), 64'(ov[g]), 64'd0);
      chk($sformatf("R13 inst%0d ready", g), 64'(rrdy[g]), 64'd1);
    end
  endtask

  task automatic t_aligned;
    run_same("R1 word", 32'h1004, 2, 0, 0, 1, bt(32'h1004, 0, 2, 1, 0), '0);
    run_same("R1 byte store", 32'h2003, 0, 1, 1, 1, bt(32'h2003, 0, 0, 1, 0), '0);
    run_same("R1 half", 32'h2006, 1, 0, 0, 1, bt(32'h2006, 0, 1, 1, 0), '0);
  endtask

  task automatic t_line;
    run_case("R2 fill", 32'h3018, 3, 2, 4,
      1, bt(32'h3018, 7, 3, 2, 0), '0, 1, bt(32'h3010, 3, 4, 2, 0), '0,
      1, bt(32'h3018, 7, 3, 2, 0), '0);
    run_case("R3 evict", 32'h3018, 3, 2, 5,
      1, bt(32'h3018, 7, 3, 1, 0), '0, 1, bt(32'h3010, 3, 4, 1, 0), '0,
      1, bt(32'h3018, 7, 3, 1, 0), '0);
  endtask

  task automatic t_lock;
    run_same("R4 swap", 32'h4008, 2, 0, 2, 1, bt(32'h4008, 0, 2, 1, 2), '0);
    run_same("R4 excl", 32'h4010, 3, 0, 3, 1, bt(32'h4010, 0, 3, 1, 1), '0);
  endtask

  task automatic t_cross16;
    run_same("R5 word", 32'h500E, 2, 0, 0, 2, bt(32'h500C, 0, 2, 1, 0), bt(32'h5010, 0, 2, 1, 0));
    run_same("R5 half", 32'h500F, 1, 0, 1, 2, bt(32'h500E, 0, 1, 1, 0), bt(32'h5010, 0, 1, 1, 0));
  endtask

  task automatic t_cross8;
    run_case("R6 word", 32'h5006, 2, 0, 0,
      1, bt(32'h5004, 1, 2, 1, 0), '0, 1, bt(32'h5000, 0, 4, 1, 0), '0,
      1, bt(32'h5004, 1, 2, 1, 0), '0);
  endtask

  task automatic t_inside;
    run_same("R7 word", 32'h5001, 2, 0, 0, 1, bt(32'h5000, 0, 3, 1, 0), '0);
    run_same("R7 half", 32'h5001, 1, 0, 0, 1, bt(32'h5000, 0, 2, 1, 0), '0);
  endtask

  task automatic t_dword_split;
    run_same("R8 device store", 32'h6004, 3, 1, 1, 2, bt(32'h6004, 0, 2, 1, 0), bt(32'h6008, 0, 2, 1, 0));
    run_same("R8 nc load", 32'h600C, 3, 0, 0, 2, bt(32'h600C, 0, 2, 1, 0), bt(32'h6010, 0, 2, 1, 0));
  endtask

  task automatic t_wcomb;
    run_case("R9 nc store", 32'h7004, 3, 0, 1,
      1, bt(32'h7004, 1, 2, 1, 0), '0, 1, bt(32'h7000, 0, 4, 1, 0), '0,
      2, bt(32'h7004, 0, 2, 1, 0), bt(32'h7008, 0, 2, 1, 0));
  endtask

  task automatic t_walk;
    run_same("R10 walk", 32'h8007, 0, 1, 6, 1, bt(32'h8004, 0, 2, 1, 0), '0);
  endtask

  task automatic t_stall;
    ordy[0] = 1'b0;
    @(negedge clk);
    raddr = 32'h900E; rsize = 2; rattr = 0; rkind = 0; rv = 1'b1;
    @(negedge clk);
    rv = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R11 held valid", 64'(ov[0]), 64'd1);
      chk("R11 held first", 64'(oa[0]), 64'h900C);
      chk("R12 ready low first", 64'(rrdy[0]), 64'd0);
      @(negedge clk);
    end
    ordy[0] = 1'b1;
    @(negedge clk);
    chk("R11 second valid", 64'(ov[0]), 64'd1);
    chk("R11 second addr", 64'(oa[0]), 64'h9010);
    chk("R12 ready low second", 64'(rrdy[0]), 64'd0);
    @(negedge clk);
    chk("R12 idle valid", 64'(ov[0]), 64'd0);
    chk("R12 ready back", 64'(rrdy[0]), 64'd1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int g = 0; g < NI; g++) ordy[g] = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_line();
    t_lock();
    t_cross16();
    t_cross8();
    t_inside();
    t_dword_split();
    t_wcomb();
    t_walk();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule